// File: doc/BRIEF.md
# Seconds-Counter Real-Time Clock with Alarm

This peripheral keeps time as a 32-bit count of seconds and sits on a 16-bit register bus. Software programs a frequency word with the rate of the input clock in Hz. A prescaler counts input clocks against that word and advances the seconds counter once per second while counting is enabled. Every 32-bit quantity is reached as two 16-bit halves, with the low half at the lower address.

Software never touches the running counter directly. To set the time it writes a 32-bit load value and raises a load request bit in the control register. To read the time it raises a snapshot request bit and then reads the captured value. Each request bit reads back as 1 while its transfer is under way and clears itself when the transfer is done. An alarm comparator checks the counter against a match value and latches a pending alarm. That alarm drives an interrupt line which software can mask, force or clear. A soft-reset bit in the control register, active low, holds the time-keeping state at zero.

Top module: `sec_rtc`

## Requirements
- R1: After the reset input is released, the control word, status, load value, match value and snapshot all read 0, the frequency word reads 1, and `irq_o` is 0.
- R2: Registers sit at these byte offsets: 0x00 control, 0x04/0x08 frequency word low/high, 0x0C/0x10 load value low/high, 0x14/0x18 match value low/high, 0x1C status, 0x20/0x24 snapshot low/high. Frequency, load and match halves read back what was written. Unmapped offsets read 0.
- R3: The control bits are: bit0 run (soft reset, active low), bit1 count enable, bit2 wrap enable, bit3 load request, bit4 snapshot request, bit5 mask, bit6 force, bit7 clear. While run and count enable are both 1 and the frequency word is F ≥ 1, the counter advances by one every F clocks. While count enable is 0, neither the counter nor the prescaler moves.
- R4: Writing control with bit3 = 1 makes bit3 read 1 after that edge and after the next one. On the second edge after the write, the counter takes the load value and bit3 returns to 0.
- R5: Writing control with bit4 = 1 behaves with the same timing. On the second edge after the write, the snapshot registers capture the counter as it stood before that edge.
- R6: With wrap enable set, the counter steps from 0xFFFFFFFF to 0.
- R7: With wrap enable clear, the counter stays at 0xFFFFFFFF on further ticks.
- R8: One clock after the counter is loaded or ticked to a value equal to the match value, the alarm latch sets and stays set until it is cleared. Status bit0 (raw) = latch OR force. Status bit1 (alarm) = raw AND NOT mask.
- R9: `irq_o` always equals status bit1, so mask = 1 holds it at 0 while raw stays visible.
- R10: A control write with bit7 = 1 clears the alarm latch on that edge, unless an alarm hit occurs in the same cycle. Bit7 always reads 0.
- R11: Force = 1 makes raw read 1 from the next cycle on. Clearing force and pulsing clear in one write returns raw to 0.
- R12: While run is 0, the counter, the prescaler and the alarm latch are held at 0.
- R13: Writes to the status and snapshot offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_en | input | 1 | Bus access valid in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address; bits [5:2] select the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the address; 0 when idle |
| irq_o | output | 1 | Alarm interrupt, level |

## Verification
The bench goes after the two-edge timing of the handshake bits. A design that finished a transfer one edge early or late would show the wrong request bit on the first read-back, or a snapshot off by one tick. It drives the counter across 0xFFFFFFFF with wrap on and with wrap off. A design that ignored wrap enable would either stick at the top when it should roll over, or roll over when it should hold. It runs the alarm through hit, mask, clear and force. A design that let the alarm fire again while the count still equals the match, or that let force linger in the latch after the clear, would raise `irq_o` where the model does not. Finally it drops run while counting is enabled, so a soft reset that missed the prescaler or the latch would show up in the next snapshot.

// File: rtl/sec_rtc.sv
module sec_rtc #(
  parameter int DW = 16,
  parameter int AW = 6,
  parameter int HS_CYCLES = 2,
  parameter logic [2*DW-1:0] FREQ_RESET = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_o
);
  localparam int CW  = 2 * DW;
  localparam int IW  = AW - 2;
  localparam int HCW = (HS_CYCLES > 1) ? $clog2(HS_CYCLES) : 1;
  localparam logic [HCW-1:0] HS_LAST = HCW'(HS_CYCLES - 1);

  localparam int B_RUN = 0, B_EN = 1, B_WRAP = 2, B_LOAD = 3;
  localparam int B_MASK = 5, B_FORCE = 6, B_CLR = 7;

  localparam logic [IW-1:0] A_CTRL = IW'(0), A_FRQ_L = IW'(1), A_FRQ_H = IW'(2);
  localparam logic [IW-1:0] A_LD_L = IW'(3), A_LD_H = IW'(4);
  localparam logic [IW-1:0] A_MT_L = IW'(5), A_MT_H = IW'(6);
  localparam logic [IW-1:0] A_STAT = IW'(7), A_SN_L = IW'(8), A_SN_H = IW'(9);

  logic [IW-1:0] idx;
  logic wr, wr_ctrl, clr;
  logic run_q, en_q, wrap_q, mask_q, force_q;
  logic [CW-1:0] freq_q, ld_q, match_q, snap_q, cnt_q, pre_q;
  logic [CW:0] pre_p1;
  logic tick, upd_q, hit, alm_q, raw;
  logic [1:0] hs_pend, hs_done;
  logic [HCW-1:0] hs_cnt [2];

  assign idx     = bus_addr[AW-1:2];
  assign wr      = bus_en & bus_we;
  assign wr_ctrl = wr && idx == A_CTRL;
  assign clr     = wr_ctrl & bus_wdata[B_CLR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {run_q, en_q, wrap_q, mask_q, force_q} <= '0;
    end else if (wr_ctrl) begin
      run_q   <= bus_wdata[B_RUN];
      en_q    <= bus_wdata[B_EN];
      wrap_q  <= bus_wdata[B_WRAP];
      mask_q  <= bus_wdata[B_MASK];
      force_q <= bus_wdata[B_FORCE];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freq_q  <= FREQ_RESET;
      ld_q    <= '0;
      match_q <= '0;
    end else if (wr) begin
      case (idx)
        A_FRQ_L: freq_q[DW-1:0]   <= bus_wdata;
        A_FRQ_H: freq_q[CW-1:DW]  <= bus_wdata;
        A_LD_L:  ld_q[DW-1:0]     <= bus_wdata;
        A_LD_H:  ld_q[CW-1:DW]    <= bus_wdata;
        A_MT_L:  match_q[DW-1:0]  <= bus_wdata;
        A_MT_H:  match_q[CW-1:DW] <= bus_wdata;
        default: ;
      endcase
    end
  end

  // index 0: load request, index 1: snapshot request
  for (genvar k = 0; k < 2; k++) begin : g_hs
    logic req;
    assign req        = wr_ctrl & bus_wdata[B_LOAD + k];
    assign hs_done[k] = hs_pend[k] && hs_cnt[k] == HS_LAST;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hs_pend[k] <= 1'b0;
        hs_cnt[k]  <= '0;
      end else if (req) begin
        hs_pend[k] <= 1'b1;
        hs_cnt[k]  <= '0;
      end else if (hs_done[k]) begin
        hs_pend[k] <= 1'b0;
      end else if (hs_pend[k]) begin
        hs_cnt[k]  <= hs_cnt[k] + 1'b1;
      end
    end
  end

  assign pre_p1 = {1'b0, pre_q} + 1'b1;
  assign tick   = run_q & en_q & (pre_p1 >= {1'b0, freq_q});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pre_q <= '0;
    else if (!run_q) pre_q <= '0;
    else if (en_q)  pre_q <= tick ? '0 : pre_p1[CW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      upd_q <= 1'b0;
    end else begin
      upd_q <= run_q & (hs_done[0] | tick);
      if (!run_q)          cnt_q <= '0;
      else if (hs_done[0]) cnt_q <= ld_q;
      else if (tick)       cnt_q <= (&cnt_q) ? (wrap_q ? '0 : cnt_q) : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          snap_q <= '0;
    else if (hs_done[1]) snap_q <= cnt_q;
  end

  assign hit = upd_q && cnt_q == match_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      alm_q <= 1'b0;
    else if (!run_q) alm_q <= 1'b0;
    else if (hit)    alm_q <= 1'b1;
    else if (clr)    alm_q <= 1'b0;
  end

  assign raw   = alm_q | force_q;
  assign irq_o = raw & ~mask_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_en) begin
      case (idx)
        A_CTRL:  bus_rdata = DW'({1'b0, force_q, mask_q, hs_pend[1], hs_pend[0], wrap_q, en_q, run_q});
        A_FRQ_L: bus_rdata = freq_q[DW-1:0];
        A_FRQ_H: bus_rdata = freq_q[CW-1:DW];
        A_LD_L:  bus_rdata = ld_q[DW-1:0];
        A_LD_H:  bus_rdata = ld_q[CW-1:DW];
        A_MT_L:  bus_rdata = match_q[DW-1:0];
        A_MT_H:  bus_rdata = match_q[CW-1:DW];
        A_STAT:  bus_rdata = DW'({irq_o, raw});
        A_SN_L:  bus_rdata = snap_q[DW-1:0];
        A_SN_H:  bus_rdata = snap_q[CW-1:DW];
        default: bus_rdata = '0;
      endcase
    end
  end

  // R12
  softrst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> (cnt_q == '0 && pre_q == '0 && !alm_q));

  // R3
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !en_q && !hs_done[0]) |=> $stable(cnt_q));

  // R3
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !hs_done[0]) |=>
      (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1 || cnt_q == '0));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !wrap_q && !hs_done[0] && (&cnt_q)) |=> (&cnt_q));

  // R4
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_done[0] && run_q) |=> cnt_q == $past(ld_q));

  // R8
  alarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && run_q) |=> alm_q);

  // R10
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hit) |=> !alm_q);
endmodule

// File: tb/sec_rtc_test.sv
module sec_rtc_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic irq_o;

  int errors = 0, checks = 0, cyc = 0;
  bit finished = 0;

  sec_rtc uut (.clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
               .bus_addr(bus_addr), .bus_wdata(bus_wdata),
               .bus_rdata(bus_rdata), .irq_o(irq_o));

  always #(CLK_P/2) clk = ~clk;

  // behavioural reference
  bit m_run, m_en, m_wrap, m_mask, m_force, m_lat, m_upd;
  bit m_ldp, m_snp;
  int m_ldc, m_snc;
  bit [31:0] m_freq, m_ld, m_match, m_snap, m_cnt, m_pre;

  function automatic bit [15:0] mrd(input int i);
    bit raw;
    raw = m_lat | m_force;
    case (i)
      0: return {8'h0, 1'b0, m_force, m_mask, m_snp, m_ldp, m_wrap, m_en, m_run};
      1: return m_freq[15:0];
      2: return m_freq[31:16];
      3: return m_ld[15:0];
      4: return m_ld[31:16];
      5: return m_match[15:0];
      6: return m_match[31:16];
      7: return {14'h0, raw & ~m_mask, raw};
      8: return m_snap[15:0];
      9: return m_snap[31:16];
      default: return 16'h0;
    endcase
  endfunction

  function automatic string tag_of(input int i);
    case (i)
      0: return "R4";
      1, 2, 3, 4, 5, 6: return "R2";
      7: return "R8";
      8, 9: return "R5";
      default: return "R13";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_run, m_en, m_wrap, m_mask, m_force, m_lat, m_upd, m_ldp, m_snp} = '0;
      m_ldc = 0; m_snc = 0;
      m_freq = 1; m_ld = 0; m_match = 0; m_snap = 0; m_cnt = 0; m_pre = 0;
    end else begin
      bit w, wc, tick, ldfin, snfin, hit, clr;
      int i;
      bit [31:0] ncnt, npre;
      cyc++;
      w = bus_en && bus_we;
      i = int'(bus_addr[5:2]);
      wc = w && i == 0;
      clr = wc && bus_wdata[7];
      tick = m_run && m_en && (longint'(m_pre) + 1 >= longint'(m_freq));
      ldfin = m_ldp && m_ldc == 1;
      snfin = m_snp && m_snc == 1;
      hit = m_upd && m_cnt == m_match;
      npre = m_pre;
      if (!m_run) npre = 0;
      else if (m_en) npre = tick ? 0 : m_pre + 1;
      ncnt = m_cnt;
      if (!m_run) ncnt = 0;
      else if (ldfin) ncnt = m_ld;
      else if (tick) ncnt = (m_cnt == 32'hFFFF_FFFF) ? (m_wrap ? 0 : m_cnt) : m_cnt + 1;
      if (snfin) m_snap = m_cnt;
      if (!m_run) m_lat = 0;
      else if (hit) m_lat = 1;
      else if (clr) m_lat = 0;
      m_upd = m_run && (ldfin || tick);
      m_cnt = ncnt;
      m_pre = npre;
      if (wc && bus_wdata[3]) begin m_ldp = 1; m_ldc = 0; end
      else if (ldfin) m_ldp = 0;
      else if (m_ldp) m_ldc++;
      if (wc && bus_wdata[4]) begin m_snp = 1; m_snc = 0; end
      else if (snfin) m_snp = 0;
      else if (m_snp) m_snc++;
      if (wc) begin
        m_run = bus_wdata[0]; m_en = bus_wdata[1]; m_wrap = bus_wdata[2];
        m_mask = bus_wdata[5]; m_force = bus_wdata[6];
      end
      if (w) begin
        case (i)
          1: m_freq[15:0] = bus_wdata;
          2: m_freq[31:16] = bus_wdata;
          3: m_ld[15:0] = bus_wdata;
          4: m_ld[31:16] = bus_wdata;
          5: m_match[15:0] = bus_wdata;
          6: m_match[31:16] = bus_wdata;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #2;
    if (rst_n && !finished) begin
      chk("R9 irq_o", int'(irq_o), int'(mrd(7) >> 1));
      if (bus_en && !bus_we)
        chk(tag_of(int'(bus_addr[5:2])), int'(bus_rdata), int'(mrd(int'(bus_addr[5:2]))));
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000 && !finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wr(input int i, input logic [15:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = 6'(i << 2); bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input int i, output logic [15:0] v);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = 6'(i << 2);
    #1 v = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      bus_en = 0; bus_we = 0;
    end
  endtask

  task automatic snap(input logic [15:0] ctl);
    wr(0, ctl | 16'h0010);
    idle(3);
  endtask

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(0, v); chk("R1 ctrl", v, 0);
    rd(7, v); chk("R1 status", v, 0);
    chk("R1 irq", int'(irq_o), 0);
    rd(1, v); chk("R1 freq", v, 1);
    rd(8, v); chk("R1 snap", v, 0);

    // R4 load with counting off, R2 halves
    wr(0, 16'h0001);
    wr(1, 16'd4); wr(2, 16'h0);
    wr(3, 16'h5678); wr(4, 16'h1234);
    rd(3, v); chk("R2 load lo", v, 16'h5678);
    wr(0, 16'h0009);
    rd(0, v); chk("R4 pending", v, 16'h0009);
    rd(0, v); chk("R4 done", v, 16'h0001);
    snap(16'h0001);
    rd(8, v); chk("R5 snap lo", v, 16'h5678);
    rd(9, v); chk("R3 frozen hi", v, 16'h1234);

    // R3 counting at 4 clocks per second
    wr(0, 16'h0003);
    idle(41);
    snap(16'h0003);
    rd(8, v); chk("R3 count lo", v, int'(m_snap[15:0]));
    chk("R3 advanced", int'(m_snap > 32'h1234_5678), 1);

    // R6 wrap on
    wr(1, 16'd1);
    wr(3, 16'hFFFD); wr(4, 16'hFFFF);
    wr(0, 16'h000F);
    idle(10);
    snap(16'h0007);
    rd(9, v); chk("R6 wrapped hi", v, 0);
    rd(8, v); chk("R6 wrapped lo", v, int'(m_snap[15:0]));

    // R7 wrap off
    wr(0, 16'h000B);
    idle(10);
    snap(16'h0003);
    rd(8, v); chk("R7 hold lo", v, 16'hFFFF);
    rd(9, v); chk("R7 hold hi", v, 16'hFFFF);

    // R8 alarm
    wr(0, 16'h0081);
    rd(7, v); chk("R10 cleared", v, 0);
    wr(1, 16'd2);
    wr(5, 16'h0100); wr(6, 16'h0000);
    rd(5, v); chk("R2 match lo", v, 16'h0100);
    wr(3, 16'h00FE); wr(4, 16'h0000);
    wr(0, 16'h0009);
    idle(3);
    rd(7, v); chk("R8 no early alarm", v, 0);
    wr(0, 16'h0003);
    idle(12);
    rd(7, v); chk("R8 alarm status", v, 3);
    chk("R9 irq raised", int'(irq_o), 1);
    wr(0, 16'h0023);
    rd(7, v); chk("R9 masked status", v, 1);
    chk("R9 masked irq", int'(irq_o), 0);
    wr(0, 16'h0083);
    rd(7, v); chk("R10 clear", v, 0);
    rd(0, v); chk("R10 clear bit reads 0", int'(v[7]), 0);

    // R11 force
    wr(0, 16'h0041);
    rd(7, v); chk("R11 forced", v, 3);
    chk("R11 forced irq", int'(irq_o), 1);
    wr(0, 16'h0081);
    rd(7, v); chk("R11 unforced", v, 0);

    // R12 soft reset
    wr(3, 16'h0777); wr(0, 16'h0009);
    idle(3);
    wr(0, 16'h0002);
    idle(4);
    snap(16'h0003);
    rd(8, v); chk("R12 zeroed lo", v, 0);
    rd(9, v); chk("R12 zeroed hi", v, 0);

    // R13 ignored writes
    wr(0, 16'h0041);
    wr(7, 16'h0000);
    rd(7, v); chk("R13 status kept", v, 3);
    wr(0, 16'h0001);
    wr(8, 16'hABCD); wr(9, 16'h1234);
    rd(8, v); chk("R13 snap lo kept", v, 0);
    rd(9, v); chk("R13 snap hi kept", v, 0);
    rd(12, v); chk("R2 unmapped", v, 0);

    idle(2);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule